// File: doc/BRIEF.md
# Selectable Inertial Delay Element

This block delays a single-bit signal by a number of clock cycles. Each delay set has separate rise and fall values, and each set holds a minimum, a typical and a maximum value. A select input picks one of the three corners. Select code zero defers to a global default register instead.

Any corner whose valid bit is clear is derived from the corners that are present. The derivation uses 8-bit fractional fixed-point scale factors and rounds to the nearest cycle.

In the default inertial mode, a pending output edge is cancelled when the input reverses before that edge matures. A pulse narrower than the delay therefore never reaches the output. When a rejection threshold is enabled, a cancelled pulse that was at least the threshold wide is reported on an unknown-marker output instead of vanishing silently. A transport mode replaces the inertial path with a tapped shift line, so pulses of any width come through intact.

Configuration goes through a simple write port. `cfg_addr` selects the field:

| Address | Field |
|---|---|
| 0 | rise minimum |
| 1 | rise typical |
| 2 | rise maximum |
| 3 | fall minimum |
| 4 | fall typical |
| 5 | fall maximum |
| 6 | default select |
| 7 | rejection threshold |

For fields 0 to 5 and for field 7, `cfg_vld` is written as the valid or enable bit.

Top module: `edge_delay_unit`

## Requirements
- R1: After reset, `dout` and `dx` are 0, every delay valid bit is clear, the threshold is disabled, and the default select register holds 2 (typical).
- R2: `dly_sel` = 1 selects the minimum set, 2 the typical set and 3 the maximum set. An input change first sampled on clock edge k reaches `dout` on edge k+D, where D is the active delay for that edge direction.
- R3: `dly_sel` = 0 uses the default select register. That register is written at address 6 from `cfg_val[1:0]`, and a write of 0 leaves it unchanged.
- R4: With the typical value valid, a missing minimum becomes (typ*102+128)>>8, and a missing maximum becomes (typ*410+128)>>8. A derived maximum saturates at 2^DW-1.
- R5: With the typical value missing, it is derived as follows:
  - When both the minimum and the maximum are valid, it becomes (min+max+1)>>1.
  - When only the minimum is valid, it becomes (min*640+128)>>8.
  - When only the maximum is valid, it becomes (max*160+128)>>8.
  - The missing minimum or maximum is then derived from that typical value as in R4.
- R6: When all three valid bits of a set are clear, its delays are 0, and `dout` takes the new input value on edge k itself.
- R7: Addresses 0 to 2 hold the rise set, which governs 0-to-1 changes. Addresses 3 to 5 hold the fall set, which governs 1-to-0 changes.
- R8: In inertial mode (`transport` = 0), a pulse held for w sampled cycles passes if w is at least the delay of its leading edge. If w is shorter, the pulse is swallowed and `dout` does not change.
- R9: With the threshold enabled (address 7, `cfg_vld` = 1), a swallowed pulse of width w ≥ threshold drives `dx` high for w cycles, starting on the edge where its leading edge would have reached `dout`. A narrower pulse leaves `dx` low.
- R10: In transport mode, `dout` is the input delayed by the active rise delay, capped at TDEPTH, for pulses of any width. `dx` stays low in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration field address |
| cfg_val | input | DW | Value written to the field |
| cfg_vld | input | 1 | Valid or enable bit written with the field |
| dly_sel | input | 2 | Corner select: 0 default, 1 min, 2 typ, 3 max |
| transport | input | 1 | 1 selects transport mode, 0 inertial |
| din | input | 1 | Signal to delay |
| dout | output | 1 | Delayed signal |
| dx | output | 1 | Unknown marker for rejected mid-width pulses |

## Verification
A change on `din` is due at `dout` exactly D edges after the edge that first samples it. Because of that, the bench drives at a falling edge and counts rising edges until `dout` matches, expecting D+1. For pulses it records, one sample per cycle away from the rising edge, the cycle index of the first high `dout` and of the first high `dx`, together with how many cycles each stayed high. A pass lands at index D, and a threshold marker lands at index D for w cycles. Expected delays come from the rounding formulas in the requirements, worked out by hand.

// File: rtl/edge_delay_unit.sv
module edge_delay_unit #(
  parameter int DW     = 8,
  parameter int TDEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_val,
  input  logic          cfg_vld,
  input  logic [1:0]    dly_sel,
  input  logic          transport,
  input  logic          din,
  output logic          dout,
  output logic          dx
);
  localparam int PW = DW + 11;
  localparam int LW = $clog2(TDEPTH);
  localparam logic [PW-1:0] DMAX = PW'((1 << DW) - 1);

  function automatic logic [DW-1:0] scl(input logic [DW-1:0] a, input int k);
    logic [PW-1:0] p;
    p = (PW'(a) * PW'(k) + PW'(128)) >> 8;
    return (p > DMAX) ? DW'(DMAX) : DW'(p);
  endfunction

  function automatic logic [3*DW-1:0] derive(input logic [DW-1:0] n, t, x, input logic [2:0] v);
    logic [DW-1:0] dn, dt, dm;
    logic [DW:0]   s;
    s = {1'b0, n} + {1'b0, x} + (DW+1)'(1);
    if (v[1])              dt = t;
    else if (v[0] && v[2]) dt = DW'(s >> 1);
    else if (v[0])         dt = scl(n, 640);
    else if (v[2])         dt = scl(x, 160);
    else                   dt = '0;
    dn = v[0] ? n : scl(dt, 102);
    dm = v[2] ? x : scl(dt, 410);
    return {dm, dt, dn};
  endfunction

  function automatic logic [DW-1:0] pick(input logic [3*DW-1:0] s, input logic [1:0] e);
    case (e)
      2'd1:    return s[DW-1:0];
      2'd3:    return s[3*DW-1:2*DW];
      default: return s[2*DW-1:DW];
    endcase
  endfunction

  logic [DW-1:0] fld [6];
  logic [5:0]    fv;
  logic [1:0]    gdef;
  logic [DW-1:0] thr;
  logic          thr_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) fld[i] <= '0;
      fv     <= '0;
      gdef   <= 2'd2;
      thr    <= '0;
      thr_on <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr < 3'd6) begin
        fld[cfg_addr] <= cfg_val;
        fv[cfg_addr]  <= cfg_vld;
      end else if (cfg_addr == 3'd6) begin
        if (cfg_val[1:0] != 2'd0) gdef <= cfg_val[1:0];
      end else begin
        thr    <= cfg_val;
        thr_on <= cfg_vld;
      end
    end
  end

  logic [3*DW-1:0] rset, fset;
  logic [1:0]      eff;
  logic [DW-1:0]   rd, fd, dnew, td;
  logic [LW-1:0]   tix;

  assign rset = derive(fld[0], fld[1], fld[2], fv[2:0]);
  assign fset = derive(fld[3], fld[4], fld[5], fv[5:3]);
  assign eff  = (dly_sel == 2'd0) ? gdef : dly_sel;
  assign rd   = pick(rset, eff);
  assign fd   = pick(fset, eff);
  assign dnew = din ? rd : fd;
  assign td   = (rd > DW'(TDEPTH)) ? DW'(TDEPTH) : rd;
  assign tix  = LW'(td - DW'(1));

  logic [TDEPTH-1:0] line;
  logic              tap;
  assign tap = (td == '0) ? din : line[tix];

  logic          pend, pval, xpend;
  logic [DW-1:0] cnt, age, xcnt, xw;
  logic          commit, alive, onext, tgt, xhit;

  assign commit = pend && (cnt == '0);
  assign alive  = pend && !commit;
  assign onext  = commit ? pval : dout;
  assign tgt    = alive ? pval : onext;
  assign xhit   = thr_on && (age >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line  <= '0;
      dout  <= 1'b0;
      dx    <= 1'b0;
      pend  <= 1'b0;
      pval  <= 1'b0;
      cnt   <= '0;
      age   <= '0;
      xpend <= 1'b0;
      xcnt  <= '0;
      xw    <= '0;
    end else begin
      line <= {line[TDEPTH-2:0], din};
      if (transport) begin
        dout  <= tap;
        dx    <= 1'b0;
        pend  <= 1'b0;
        xpend <= 1'b0;
      end else begin
        dout <= onext;
        if (xpend) begin
          if (xcnt == '0) begin
            xpend <= 1'b0;
            dx    <= 1'b1;
            xw    <= xw - DW'(1);
          end else begin
            xcnt <= xcnt - DW'(1);
          end
        end else if (dx) begin
          if (xw == '0) dx <= 1'b0;
          else          xw <= xw - DW'(1);
        end
        if (din != tgt) begin
          if (alive) begin
            pend <= 1'b0;
            if (xhit) begin
              xpend <= 1'b1;
              xcnt  <= cnt - DW'(1);
              xw    <= age;
            end
          end else if (dnew == '0) begin
            dout <= din;
            pend <= 1'b0;
          end else begin
            pend <= 1'b1;
            pval <= din;
            cnt  <= dnew - DW'(1);
            age  <= DW'(1);
          end
        end else if (alive) begin
          cnt <= cnt - DW'(1);
          age <= age + DW'(1);
        end else begin
          pend <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (rst_n && fv[2:0] == 3'b010)
      assert_rise_order_R4: assert (rset[DW-1:0] <= rset[2*DW-1:DW] && rset[2*DW-1:DW] <= rset[3*DW-1:2*DW]);
  end

  assert_dflt_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n) gdef != 2'd0);
  assert_marker_source_R9: assert property (@(posedge clk) disable iff (!rst_n) $rose(dx) |-> $past(xpend));
  assert_transport_clean_R10: assert property (@(posedge clk) disable iff (!rst_n) $past(transport) |-> (!dx && !pend));
endmodule

// File: tb/test_edge_delay_unit.sv
module test_edge_delay_unit;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_val = '0;
  logic          cfg_vld = 1'b0;
  logic [1:0]    dly_sel = 2'd2;
  logic          transport = 1'b0;
  logic          din = 1'b0;
  logic          dout, dx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  edge_delay_unit #(.DW(DW), .TDEPTH(32)) i_edge_delay_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_val(cfg_val),
    .cfg_vld(cfg_vld), .dly_sel(dly_sel), .transport(transport), .din(din),
    .dout(dout), .dx(dx));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; din = 1'b0; cfg_we = 1'b0; transport = 1'b0; dly_sel = 2'd2;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wcfg(input int a, input int v, input bit vld);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_val = DW'(v); cfg_vld = vld;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(input logic v, input int expd, input string tag);
    int n;
    n = 0;
    @(negedge clk);
    din = v;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
    end while (dout != v && n < 400);
    chk(tag, n, expd + 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input int w, input int ncyc, output int first, output int hi,
                       output int xfirst, output int xc);
    first = -1; hi = 0; xfirst = -1; xc = 0;
    @(negedge clk);
    din = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); @(negedge clk);
      if (dout) begin hi++; if (first < 0) first = i; end
      if (dx) begin xc++; if (xfirst < 0) xfirst = i; end
      if (i + 1 == w) din = 1'b0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 dout after reset", int'(dout), 0);
    chk("R1 dx after reset", int'(dx), 0);
    dly_sel = 2'd0;
    measure(1'b1, 0, "R1 unconfigured delay is zero");
  endtask

  task automatic t_typ_only();
    do_reset();
    wcfg(1, 10, 1); wcfg(4, 10, 1);
    dly_sel = 2'd1; measure(1'b1, 4, "R4 derived rise min");
    measure(1'b0, 4, "R2 min corner fall");
    dly_sel = 2'd2; measure(1'b1, 10, "R2 typ corner rise");
    dly_sel = 2'd3; measure(1'b0, 16, "R4 derived fall max");
  endtask

  task automatic t_minmax();
    do_reset();
    wcfg(3, 3, 1); wcfg(5, 9, 1);
    dly_sel = 2'd2; measure(1'b1, 0, "R6 empty rise set");
    measure(1'b0, 6, "R5 average typ");
    dly_sel = 2'd1; measure(1'b1, 0, "R6 empty rise set min");
    measure(1'b0, 3, "R2 min fall");
    dly_sel = 2'd3; measure(1'b1, 0, "R6 empty rise set max");
    measure(1'b0, 9, "R2 max fall");
  endtask

  task automatic t_single_side();
    do_reset();
    wcfg(0, 4, 1);
    dly_sel = 2'd2; measure(1'b1, 10, "R5 typ from min");
    measure(1'b0, 0, "R6 empty fall set");
    dly_sel = 2'd3; measure(1'b1, 16, "R5 max via derived typ");
    do_reset();
    wcfg(2, 16, 1);
    dly_sel = 2'd2; measure(1'b1, 10, "R5 typ from max");
    measure(1'b0, 0, "R6 fall zero");
    dly_sel = 2'd1; measure(1'b1, 4, "R5 min via derived typ");
  endtask

  task automatic t_saturate();
    do_reset();
    wcfg(1, 200, 1);
    dly_sel = 2'd3; measure(1'b1, 255, "R4 saturated max");
  endtask

  task automatic t_default();
    do_reset();
    wcfg(1, 10, 1);
    dly_sel = 2'd0; measure(1'b1, 10, "R3 default is typ");
    measure(1'b0, 0, "R3 fall zero");
    wcfg(6, 3, 0); measure(1'b1, 16, "R3 default set to max");
    measure(1'b0, 0, "R3 fall zero b");
    wcfg(6, 0, 0); measure(1'b1, 16, "R3 write of 0 ignored");
    measure(1'b0, 0, "R3 fall zero c");
    wcfg(6, 1, 0); measure(1'b1, 4, "R3 default set to min");
  endtask

  task automatic t_invalid();
    do_reset();
    wcfg(1, 10, 0);
    dly_sel = 2'd2; measure(1'b1, 0, "R6 value without valid bit");
  endtask

  task automatic t_split();
    do_reset();
    wcfg(1, 3, 1); wcfg(4, 8, 1);
    dly_sel = 2'd2;
    measure(1'b1, 3, "R7 rise delay");
    measure(1'b0, 8, "R7 fall delay");
  endtask

  task automatic t_inertial();
    int f, h, xf, xc;
    do_reset();
    wcfg(1, 6, 1); wcfg(4, 6, 1);
    dly_sel = 2'd2;
    pulse(3, 40, f, h, xf, xc);
    chk("R8 short pulse swallowed", h, 0);
    chk("R8 no marker without threshold", xc, 0);
    pulse(5, 40, f, h, xf, xc);
    chk("R8 one-short pulse swallowed", h, 0);
    pulse(6, 40, f, h, xf, xc);
    chk("R8 full pulse first cycle", f, 6);
    chk("R8 full pulse width", h, 6);
  endtask

  task automatic t_reject();
    int f, h, xf, xc;
    do_reset();
    wcfg(1, 6, 1); wcfg(4, 6, 1); wcfg(7, 2, 1);
    dly_sel = 2'd2;
    pulse(4, 40, f, h, xf, xc);
    chk("R9 dout unchanged", h, 0);
    chk("R9 marker start", xf, 6);
    chk("R9 marker width", xc, 4);
    pulse(1, 40, f, h, xf, xc);
    chk("R9 below threshold no marker", xc, 0);
    chk("R9 below threshold swallowed", h, 0);
    pulse(6, 40, f, h, xf, xc);
    chk("R9 full pulse passes", h, 6);
    chk("R9 full pulse no marker", xc, 0);
  endtask

  task automatic t_transport();
    int f, h, xf, xc;
    do_reset();
    wcfg(1, 5, 1); wcfg(4, 5, 1); wcfg(7, 0, 1);
    dly_sel = 2'd2; transport = 1'b1;
    repeat (40) @(negedge clk);
    pulse(2, 60, f, h, xf, xc);
    chk("R10 pulse start", f, 5);
    chk("R10 pulse width 2", h, 2);
    chk("R10 no marker", xc, 0);
    pulse(1, 60, f, h, xf, xc);
    chk("R10 single-cycle pulse", h, 1);
    chk("R10 single-cycle start", f, 5);
    wcfg(1, 40, 1);
    repeat (40) @(negedge clk);
    pulse(3, 60, f, h, xf, xc);
    chk("R10 capped delay", f, 32);
    chk("R10 capped width", h, 3);
  endtask

  initial begin
    t_reset();
    t_typ_only();
    t_minmax();
    t_single_side();
    t_saturate();
    t_default();
    t_invalid();
    t_split();
    t_inertial();
    t_reject();
    t_transport();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule